// File: doc/BRIEF.md
# USB Host Pipe Reset and Enable Control

This block holds the per-pipe runtime and configuration state of a set of USB host pipes and decides, for each pipe, which of that state a software reset clears and which survives. Each pipe carries a configuration word, a sticky status word, a control word, a data-toggle bit, a small transfer state machine and two bank-fill counters (transmit and receive). Software drives a reset register with one bit per pipe, an enable register with one bit per pipe, and a per-pipe strobe that clears the data toggle. A bus-reset deallocation strobe clears the allocation and enable bits of every pipe at once.

A pipe is held whenever its reset bit is set or its enable bit is clear. While held, its state machine, counters, status and control are cleared and its FIFO is reported unusable; its configuration word is kept. The toggle is kept through a reset-bit hold but forced to zero while the pipe is disabled. The toggle flips on each completed transaction of a pipe that is not held. The FIFO becomes usable only once software writes the reset bit back to zero.

All register writes take effect at the next clock edge. The held condition is taken from the registered reset and enable bits, so runtime state clears one edge after the reset or enable register changes.

Top module: `usb_pipe_rst_ctrl`

## Requirements
- R1: The reset register has one bit per pipe (bit i belongs to pipe i); a write loads the whole vector at the next edge, at any time, and the value reads back on `pipe_rst_q`.
- R2: One edge after a pipe is held, its state reads 0 and its status word, control word and both bank counters read zero; control writes and status events for a held pipe have no effect.
- R3: The configuration word (bit 0 = allocated, bits 2:1 = bank count code, the rest size, token, type, endpoint number and interrupt interval) is unchanged by a reset-bit hold; a write with a select equal to or above the pipe count changes no pipe.
- R4: While a pipe's reset bit is set and it is enabled, its toggle holds its value (completions are ignored) and its enable bit stays 1.
- R5: A toggle-clear strobe on an enabled pipe makes its toggle 0 at the next edge, even when a completion arrives in the same cycle.
- R6: `fifo_ok` of a pipe is 1 only when the pipe is allocated, enabled and its reset bit is 0; it returns to 1 one edge after software clears the reset bit.
- R7: While a pipe's enable bit is 0 the pipe is held and its toggle reads 0 one edge later.
- R8: The deallocation strobe clears every enable bit and every allocation bit at the next edge, overriding an enable write in the same cycle.
- R9: A completion pulse on a pipe that is not held and sees no toggle-clear flips its toggle at the next edge.
- R10: Each bank counter rises by one on a push alone while below the bank limit (bank count code + 1), falls by one on a pop alone while above zero, and holds on push with pop.
- R11: State encoding 0 = held, 1 = ready, 2 = transferring; an unheld pipe leaves state 0 for 1, goes from 1 to 2 on a start pulse and from 2 back to 1 on a completion.
- R12: Status event bits of an unheld pipe are OR-ed into its status word and stay set until the pipe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_reg_we | input | 1 | Reset register write strobe |
| rst_reg_wdata | input | NPIPE | Reset register write value |
| en_reg_we | input | 1 | Enable register write strobe |
| en_reg_wdata | input | NPIPE | Enable register write value |
| dealloc_stb | input | 1 | Bus-reset deallocation strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Pipe selected by the configuration write |
| cfg_wdata | input | CFG_W | Configuration write value |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_sel | input | SEL_W | Pipe selected by the control write |
| ctrl_wdata | input | CTRL_W | Control write value |
| tog_clr | input | NPIPE | Per-pipe toggle-clear strobe |
| txn_done | input | NPIPE | Per-pipe transaction-complete pulse |
| xfer_start | input | NPIPE | Per-pipe transfer-start pulse |
| tx_push | input | NPIPE | Per-pipe transmit bank fill |
| tx_pop | input | NPIPE | Per-pipe transmit bank drain |
| rx_push | input | NPIPE | Per-pipe receive bank fill |
| rx_pop | input | NPIPE | Per-pipe receive bank drain |
| stat_evt | input | NPIPE*STAT_W | Per-pipe status events |
| pipe_rst_q | output | NPIPE | Reset register value |
| pipe_en_q | output | NPIPE | Enable register value |
| cfg_q | output | NPIPE*CFG_W | Per-pipe configuration words |
| tog_q | output | NPIPE | Per-pipe data toggle |
| tx_cnt_q | output | NPIPE*CNT_W | Per-pipe transmit bank count |
| rx_cnt_q | output | NPIPE*CNT_W | Per-pipe receive bank count |
| stat_q | output | NPIPE*STAT_W | Per-pipe status words |
| ctrl_q | output | NPIPE*CTRL_W | Per-pipe control words |
| state_q | output | NPIPE*2 | Per-pipe state machine state |
| fifo_ok | output | NPIPE | Per-pipe FIFO usable flag |

## Verification
The bench builds the block with its defaults: seven pipes, four-bit status and control words and three-bit bank counters. Seven pipes behind a three-bit select leave the value 7 decoding to no pipe, which the bench drives to show that such writes are dropped. The three-bit counters reach the largest bank limit of four, so both saturation at the limit and the floor at zero fall within reach of random push and pop traffic.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

    typedef struct packed {
        logic [7:0] ifreq;
        logic [3:0] epnum;
        logic [1:0] ptype;
        logic [1:0] token;
        logic [2:0] psize;
        logic [1:0] banks;
        logic       alloc;
    } pipe_cfg_t;

    localparam int CFG_W = $bits(pipe_cfg_t);

    typedef enum logic [1:0] {
        PS_HELD  = 2'd0,
        PS_READY = 2'd1,
        PS_XFER  = 2'd2
    } pipe_st_e;

    function automatic logic [2:0] bank_limit(input pipe_cfg_t c);
        return {1'b0, c.banks} + 3'd1;
    endfunction

endpackage

// File: rtl/usbp_ctl_regs.sv
module usbp_ctl_regs #(
    parameter int NPIPE = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_reg_we,
    input  logic [NPIPE-1:0] rst_reg_wdata,
    input  logic             en_reg_we,
    input  logic [NPIPE-1:0] en_reg_wdata,
    input  logic             dealloc_stb,
    output logic [NPIPE-1:0] pipe_rst_q,
    output logic [NPIPE-1:0] pipe_en_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_rst_q <= '0;
        end else if (rst_reg_we) begin
            pipe_rst_q <= rst_reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_en_q <= '0;
        end else if (dealloc_stb) begin
            pipe_en_q <= '0;
        end else if (en_reg_we) begin
            pipe_en_q <= en_reg_wdata;
        end
    end

    assert_rst_write_R1: assert property (@(posedge clk) disable iff (rst)
        rst_reg_we |=> pipe_rst_q == $past(rst_reg_wdata));

    assert_dealloc_en_R8: assert property (@(posedge clk) disable iff (rst)
        dealloc_stb |=> pipe_en_q == '0);

endmodule

// File: rtl/usbp_bank_cnt.sv
module usbp_bank_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] lim,
    input  logic             push,
    input  logic             pop,
    output logic [CNT_W-1:0] cnt_q
);

    logic inc, dec;

    always_comb begin
        inc = push && !pop && (cnt_q < lim);
        dec = pop && !push && (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_cnt_sat_R10: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !clr && cnt_q >= lim) |=> $stable(cnt_q));

    assert_cnt_floor_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !clr && cnt_q == '0) |=> cnt_q == '0);

    assert_cnt_clr_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/usbp_pipe.sv
module usbp_pipe
    import usbp_pkg::*;
#(
    parameter int STAT_W = 4,
    parameter int CTRL_W = 4,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_bit,
    input  logic              en_bit,
    input  logic              dealloc,
    input  logic              cfg_we,
    input  pipe_cfg_t         cfg_wdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tog_clr,
    input  logic              txn_done,
    input  logic              xfer_start,
    input  logic              tx_push,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic [STAT_W-1:0] stat_evt,
    output pipe_cfg_t         cfg_q,
    output logic              tog_q,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic [STAT_W-1:0] stat_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output pipe_st_e          state_q,
    output logic              fifo_ok
);

    logic             held;
    logic [CNT_W-1:0] lim;
    pipe_st_e         state_d;

    always_comb begin
        held    = rst_bit || !en_bit;
        lim     = CNT_W'(bank_limit(cfg_q));
        fifo_ok = !held && cfg_q.alloc;
    end

    // configuration: outside the held-clear domain
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q <= cfg_wdata;
            end
            if (dealloc) begin
                cfg_q.alloc <= 1'b0;
            end
        end
    end

    // data toggle: kept through reset-bit hold, cleared when disabled
    always_ff @(posedge clk) begin
        if (rst || !en_bit || tog_clr) begin
            tog_q <= 1'b0;
        end else if (txn_done && !held) begin
            tog_q <= !tog_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || held) begin
            stat_q <= '0;
            ctrl_q <= '0;
        end else begin
            stat_q <= stat_q | stat_evt;
            if (ctrl_we) begin
                ctrl_q <= ctrl_wdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (held) begin
            state_d = PS_HELD;
        end else begin
            case (state_q)
                PS_HELD:  state_d = PS_READY;
                PS_READY: if (xfer_start) state_d = PS_XFER;
                PS_XFER:  if (txn_done)   state_d = PS_READY;
                default:  state_d = PS_HELD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    usbp_bank_cnt #(.CNT_W(CNT_W)) u_tx_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (held),
        .lim   (lim),
        .push  (tx_push),
        .pop   (tx_pop),
        .cnt_q (tx_cnt)
    );

    usbp_bank_cnt #(.CNT_W(CNT_W)) u_rx_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (held),
        .lim   (lim),
        .push  (rx_push),
        .pop   (rx_pop),
        .cnt_q (rx_cnt)
    );

    assert_held_clear_R2: assert property (@(posedge clk) disable iff (rst)
        held |=> (state_q == PS_HELD && stat_q == '0 && ctrl_q == '0));

    assert_cfg_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (rst_bit && !cfg_we && !dealloc) |=> $stable(cfg_q));

    assert_tog_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_bit && en_bit && !tog_clr) |=> $stable(tog_q));

    assert_tog_clr_R5: assert property (@(posedge clk) disable iff (rst)
        (en_bit && tog_clr) |=> !tog_q);

    assert_fifo_gate_R6: assert property (@(posedge clk) disable iff (rst)
        rst_bit |-> !fifo_ok);

    assert_dis_tog_R7: assert property (@(posedge clk) disable iff (rst)
        !en_bit |=> !tog_q);

    assert_tog_flip_R9: assert property (@(posedge clk) disable iff (rst)
        (!held && txn_done && !tog_clr) |=> tog_q != $past(tog_q));

    assert_start_xfer_R11: assert property (@(posedge clk) disable iff (rst)
        (!held && state_q == PS_READY && xfer_start) |=> state_q == PS_XFER);

    assert_stat_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (!held && stat_q != '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/usb_pipe_rst_ctrl.sv
module usb_pipe_rst_ctrl
    import usbp_pkg::*;
#(
    parameter int NPIPE  = 7,
    parameter int STAT_W = 4,
    parameter int CTRL_W = 4,
    parameter int CNT_W  = 3,
    localparam int SEL_W = (NPIPE > 1) ? $clog2(NPIPE) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rst_reg_we,
    input  logic [NPIPE-1:0]         rst_reg_wdata,
    input  logic                     en_reg_we,
    input  logic [NPIPE-1:0]         en_reg_wdata,
    input  logic                     dealloc_stb,
    input  logic                     cfg_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [CFG_W-1:0]         cfg_wdata,
    input  logic                     ctrl_we,
    input  logic [SEL_W-1:0]         ctrl_sel,
    input  logic [CTRL_W-1:0]        ctrl_wdata,
    input  logic [NPIPE-1:0]         tog_clr,
    input  logic [NPIPE-1:0]         txn_done,
    input  logic [NPIPE-1:0]         xfer_start,
    input  logic [NPIPE-1:0]         tx_push,
    input  logic [NPIPE-1:0]         tx_pop,
    input  logic [NPIPE-1:0]         rx_push,
    input  logic [NPIPE-1:0]         rx_pop,
    input  logic [NPIPE*STAT_W-1:0]  stat_evt,
    output logic [NPIPE-1:0]         pipe_rst_q,
    output logic [NPIPE-1:0]         pipe_en_q,
    output logic [NPIPE*CFG_W-1:0]   cfg_q,
    output logic [NPIPE-1:0]         tog_q,
    output logic [NPIPE*CNT_W-1:0]   tx_cnt_q,
    output logic [NPIPE*CNT_W-1:0]   rx_cnt_q,
    output logic [NPIPE*STAT_W-1:0]  stat_q,
    output logic [NPIPE*CTRL_W-1:0]  ctrl_q,
    output logic [NPIPE*2-1:0]       state_q,
    output logic [NPIPE-1:0]         fifo_ok
);

    usbp_ctl_regs #(.NPIPE(NPIPE)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .rst_reg_we    (rst_reg_we),
        .rst_reg_wdata (rst_reg_wdata),
        .en_reg_we     (en_reg_we),
        .en_reg_wdata  (en_reg_wdata),
        .dealloc_stb   (dealloc_stb),
        .pipe_rst_q    (pipe_rst_q),
        .pipe_en_q     (pipe_en_q)
    );

    for (genvar gi = 0; gi < NPIPE; gi++) begin : g_pipe
        logic      cfg_hit, ctrl_hit;
        pipe_cfg_t cfg_o;
        pipe_st_e  st_o;

        always_comb begin
            cfg_hit  = cfg_we  && (32'(cfg_sel)  == gi);
            ctrl_hit = ctrl_we && (32'(ctrl_sel) == gi);
        end

        usbp_pipe #(
            .STAT_W (STAT_W),
            .CTRL_W (CTRL_W),
            .CNT_W  (CNT_W)
        ) u_pipe (
            .clk        (clk),
            .rst        (rst),
            .rst_bit    (pipe_rst_q[gi]),
            .en_bit     (pipe_en_q[gi]),
            .dealloc    (dealloc_stb),
            .cfg_we     (cfg_hit),
            .cfg_wdata  (pipe_cfg_t'(cfg_wdata)),
            .ctrl_we    (ctrl_hit),
            .ctrl_wdata (ctrl_wdata),
            .tog_clr    (tog_clr[gi]),
            .txn_done   (txn_done[gi]),
            .xfer_start (xfer_start[gi]),
            .tx_push    (tx_push[gi]),
            .tx_pop     (tx_pop[gi]),
            .rx_push    (rx_push[gi]),
            .rx_pop     (rx_pop[gi]),
            .stat_evt   (stat_evt[gi*STAT_W +: STAT_W]),
            .cfg_q      (cfg_o),
            .tog_q      (tog_q[gi]),
            .tx_cnt     (tx_cnt_q[gi*CNT_W +: CNT_W]),
            .rx_cnt     (rx_cnt_q[gi*CNT_W +: CNT_W]),
            .stat_q     (stat_q[gi*STAT_W +: STAT_W]),
            .ctrl_q     (ctrl_q[gi*CTRL_W +: CTRL_W]),
            .state_q    (st_o),
            .fifo_ok    (fifo_ok[gi])
        );

        assign cfg_q[gi*CFG_W +: CFG_W] = cfg_o;
        assign state_q[gi*2 +: 2]       = st_o;
    end

endmodule

// File: tb/usb_pipe_rst_ctrl_test.sv
module usb_pipe_rst_ctrl_test;
    localparam int NP = 7;
    localparam int SW = 4;
    localparam int CW = 4;
    localparam int NW = 3;
    localparam int FW = 22;
    localparam int SL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          rst_reg_we, en_reg_we, dealloc_stb, cfg_we, ctrl_we;
    logic [NP-1:0] rst_reg_wdata, en_reg_wdata;
    logic [SL-1:0] cfg_sel, ctrl_sel;
    logic [FW-1:0] cfg_wdata;
    logic [CW-1:0] ctrl_wdata;
    logic [NP-1:0] tog_clr, txn_done, xfer_start, tx_push, tx_pop, rx_push, rx_pop;
    logic [NP*SW-1:0] stat_evt;

    logic [NP-1:0]    pipe_rst_q, pipe_en_q, tog_q, fifo_ok;
    logic [NP*FW-1:0] cfg_q;
    logic [NP*NW-1:0] tx_cnt_q, rx_cnt_q;
    logic [NP*SW-1:0] stat_q;
    logic [NP*CW-1:0] ctrl_q;
    logic [NP*2-1:0]  state_q;

    usb_pipe_rst_ctrl uut (.*);

    // bench model
    logic [NP-1:0] m_rst, m_en, m_tog;
    logic [FW-1:0] m_cfg [NP];
    int            m_tx [NP], m_rx [NP], m_st [NP];
    logic [SW-1:0] m_stat [NP];
    logic [CW-1:0] m_ctrl [NP];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    function automatic int lim_of(input logic [FW-1:0] c);
        return int'(c[2:1]) + 1;
    endfunction

    function automatic int cnt_next(input int c, input int lim, input bit held,
                                    input logic p, input logic q);
        if (held) return 0;
        if (p && !q && c < lim) return c + 1;
        if (q && !p && c > 0) return c - 1;
        return c;
    endfunction

    function automatic int st_next(input int s, input bit held, input logic go, input logic dn);
        if (held) return 0;
        if (s == 0) return 1;
        if (s == 1 && go) return 2;
        if (s == 2 && dn) return 1;
        return s;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        rst_reg_we = 0; en_reg_we = 0; dealloc_stb = 0; cfg_we = 0; ctrl_we = 0;
        rst_reg_wdata = '0; en_reg_wdata = '0; cfg_sel = '0; ctrl_sel = '0;
        cfg_wdata = '0; ctrl_wdata = '0;
        tog_clr = '0; txn_done = '0; xfer_start = '0;
        tx_push = '0; tx_pop = '0; rx_push = '0; rx_pop = '0; stat_evt = '0;
    endtask

    task automatic model_reset();
        m_rst = '0; m_en = '0; m_tog = '0;
        for (int i = 0; i < NP; i++) begin
            m_cfg[i] = '0; m_tx[i] = 0; m_rx[i] = 0; m_st[i] = 0;
            m_stat[i] = '0; m_ctrl[i] = '0;
        end
    endtask

    task automatic compare_all();
        chk(int'(pipe_rst_q), int'(m_rst), "R1 reset register");
        chk(int'(pipe_en_q), int'(m_en), "R8 enable register");
        for (int i = 0; i < NP; i++) begin
            bit held = m_rst[i] | ~m_en[i];
            chk(int'(cfg_q[i*FW +: FW]), int'(m_cfg[i]), "R3 config");
            chk(int'(tog_q[i]), int'(m_tog[i]), "R9 toggle");
            chk(int'(tx_cnt_q[i*NW +: NW]), m_tx[i], "R10 tx count");
            chk(int'(rx_cnt_q[i*NW +: NW]), m_rx[i], "R10 rx count");
            chk(int'(stat_q[i*SW +: SW]), int'(m_stat[i]), "R12 status");
            chk(int'(ctrl_q[i*CW +: CW]), int'(m_ctrl[i]), "R2 control");
            chk(int'(state_q[i*2 +: 2]), m_st[i], "R11 state");
            chk(int'(fifo_ok[i]), int'(!held && m_cfg[i][0]), "R6 fifo_ok");
        end
    endtask

    task automatic step();
        logic [NP-1:0] n_rst, n_en, n_tog;
        logic [FW-1:0] n_cfg [NP];
        int            n_tx [NP], n_rx [NP], n_st [NP];
        logic [SW-1:0] n_stat [NP];
        logic [CW-1:0] n_ctrl [NP];
        n_rst = rst_reg_we ? rst_reg_wdata : m_rst;
        n_en  = dealloc_stb ? '0 : (en_reg_we ? en_reg_wdata : m_en);
        for (int i = 0; i < NP; i++) begin
            bit held = m_rst[i] | ~m_en[i];
            n_cfg[i] = (cfg_we && int'(cfg_sel) == i) ? cfg_wdata : m_cfg[i];
            if (dealloc_stb) n_cfg[i][0] = 1'b0;
            if (!m_en[i] || tog_clr[i]) n_tog[i] = 1'b0;
            else if (txn_done[i] && !held) n_tog[i] = ~m_tog[i];
            else n_tog[i] = m_tog[i];
            n_tx[i] = cnt_next(m_tx[i], lim_of(m_cfg[i]), held, tx_push[i], tx_pop[i]);
            n_rx[i] = cnt_next(m_rx[i], lim_of(m_cfg[i]), held, rx_push[i], rx_pop[i]);
            n_stat[i] = held ? '0 : (m_stat[i] | stat_evt[i*SW +: SW]);
            n_ctrl[i] = held ? '0 : ((ctrl_we && int'(ctrl_sel) == i) ? ctrl_wdata : m_ctrl[i]);
            n_st[i] = st_next(m_st[i], held, xfer_start[i], txn_done[i]);
        end
        @(posedge clk);
        m_rst = n_rst; m_en = n_en; m_tog = n_tog;
        for (int i = 0; i < NP; i++) begin
            m_cfg[i] = n_cfg[i]; m_tx[i] = n_tx[i]; m_rx[i] = n_rx[i];
            m_stat[i] = n_stat[i]; m_ctrl[i] = n_ctrl[i]; m_st[i] = n_st[i];
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_inputs();
        idle();
        rst_reg_we    = ($urandom_range(0, 15) == 0);
        rst_reg_wdata = NP'($urandom);
        en_reg_we     = ($urandom_range(0, 11) == 0);
        en_reg_wdata  = NP'($urandom) | NP'($urandom);
        dealloc_stb   = ($urandom_range(0, 79) == 0);
        cfg_we        = ($urandom_range(0, 5) == 0);
        cfg_sel       = SL'($urandom);
        cfg_wdata     = FW'($urandom) | 22'h1;
        ctrl_we       = ($urandom_range(0, 3) == 0);
        ctrl_sel      = SL'($urandom);
        ctrl_wdata    = CW'($urandom);
        tog_clr       = NP'($urandom) & NP'($urandom) & NP'($urandom);
        txn_done      = NP'($urandom) & NP'($urandom);
        xfer_start    = NP'($urandom);
        tx_push       = NP'($urandom);
        tx_pop        = NP'($urandom) & NP'($urandom);
        rx_push       = NP'($urandom);
        rx_pop        = NP'($urandom) & NP'($urandom);
        stat_evt      = (NP*SW)'({$urandom, $urandom}) & (NP*SW)'({$urandom, $urandom})
                        & (NP*SW)'({$urandom, $urandom});
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all(); // reset state: all pipes held, nothing usable

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            rand_inputs();
            step();
        end

        // R8: deallocation beats a same-cycle enable write
        idle();
        dealloc_stb = 1; en_reg_we = 1; en_reg_wdata = '1;
        step();
        chk(int'(pipe_en_q), 0, "R8 dealloc over enable");
        chk(int'(cfg_q[0]), 0, "R8 alloc bit cleared");

        // bring pipe 0 up: allocated, bank code 2 (limit 3)
        idle();
        rst_reg_we = 1; rst_reg_wdata = '0;
        en_reg_we = 1; en_reg_wdata = '1;
        cfg_we = 1; cfg_sel = 0; cfg_wdata = 22'h5;
        step();
        idle();
        step();
        chk(int'(state_q[1:0]), 1, "R11 ready after release");
        chk(int'(fifo_ok[0]), 1, "R6 usable when allocated and enabled");

        // R9: completion flips toggle
        txn_done[0] = 1;
        step();
        idle();
        chk(int'(tog_q[0]), 1, "R9 toggle flipped");

        // R1/R6: set reset bit while in use
        rst_reg_we = 1; rst_reg_wdata = 7'h01;
        step();
        idle();
        chk(int'(pipe_rst_q[0]), 1, "R1 reset bit set");
        chk(int'(fifo_ok[0]), 0, "R6 unusable under reset");

        // R4/R2: completion and push ignored under reset bit
        txn_done[0] = 1; tx_push[0] = 1; ctrl_we = 1; ctrl_sel = 0; ctrl_wdata = 4'hA;
        stat_evt[3:0] = 4'hF;
        step();
        idle();
        chk(int'(tog_q[0]), 1, "R4 toggle kept under reset");
        chk(int'(pipe_en_q[0]), 1, "R4 enable kept under reset");
        chk(int'(tx_cnt_q[NW-1:0]), 0, "R2 counter held");
        chk(int'(ctrl_q[CW-1:0]), 0, "R2 control write ignored");
        chk(int'(stat_q[SW-1:0]), 0, "R2 status event ignored");
        chk(int'(cfg_q[FW-1:0]), 32'h5, "R3 config kept under reset");

        // R6: clearing the reset bit restores use
        rst_reg_we = 1; rst_reg_wdata = '0;
        step();
        idle();
        chk(int'(fifo_ok[0]), 1, "R6 usable after clear");

        // R5: clear wins over completion
        tog_clr[0] = 1; txn_done[0] = 1;
        step();
        idle();
        chk(int'(tog_q[0]), 0, "R5 toggle cleared");

        // R3: select 7 reaches no pipe
        cfg_we = 1; cfg_sel = 3'd7; cfg_wdata = 22'h3FFFFF;
        step();
        idle();
        chk(int'(cfg_q[FW-1:0]), 32'h5, "R3 out-of-range select ignored");

        // R10: saturate at limit 3, hold on push+pop
        for (int k = 0; k < 5; k++) begin
            tx_push[0] = 1;
            step();
        end
        idle();
        chk(int'(tx_cnt_q[NW-1:0]), 3, "R10 saturate at limit");
        tx_push[0] = 1; tx_pop[0] = 1;
        step();
        idle();
        chk(int'(tx_cnt_q[NW-1:0]), 3, "R10 push with pop holds");

        // R11: start then completion
        xfer_start[0] = 1;
        step();
        idle();
        chk(int'(state_q[1:0]), 2, "R11 transferring");
        txn_done[0] = 1;
        step();
        idle();
        chk(int'(state_q[1:0]), 1, "R11 back to ready");

        // R12: sticky status
        stat_evt[1:0] = 2'b10;
        step();
        idle();
        stat_evt[1:0] = 2'b01;
        step();
        idle();
        chk(int'(stat_q[SW-1:0]), 3, "R12 status sticky");

        // R7: disable clears toggle and holds the pipe
        txn_done[0] = 1;
        step();
        idle();
        en_reg_we = 1; en_reg_wdata = 7'h7E;
        step();
        idle();
        step();
        chk(int'(tog_q[0]), 0, "R7 toggle cleared when disabled");
        chk(int'(state_q[1:0]), 0, "R7 held when disabled");
        chk(int'(stat_q[SW-1:0]), 0, "R7 status cleared when disabled");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule